// File: doc/BRIEF.md
# Bank-Select Write Sequencer

This block issues a single write on a cartridge bus whose low address byte and data byte share the same eight AD lines. Its one job is to deliver a bank-switch byte to the fixed switch register at address 0xFFFF. An upstream detector supplies two switch values, one for the lower half of the cartridge and one for the upper half. A one-bit select chooses which of the two is written.

The host raises a request while the block is idle. The sequencer then runs a fixed series of phases. First comes a short low pulse on the first chip-select. Next the second chip-select goes low and stays low. The address is latched by raising and then dropping latch-enable while the low address byte sits on AD. Then comes a timed write-enable low window, during which the switch byte is driven. At the end, write-enable and the second chip-select are released together and a one-cycle done pulse is raised. The width of the write-enable window is derived from the clock frequency. The AD drivers are enabled only while the address or the data is on the lines.

Top module: `bank_wr_seq`

## Requirements
- R1: After reset and whenever idle, cs1_n_o, cs2_n_o and we_n_o are 1, le_o, ad_oe_o and done_o are 0, and addr_hi_o is 0x00. An asynchronous reset during a cycle returns the block to this state at once.
- R2: A request is sampled on the rising edge while idle. For the one cycle after that edge (cycle 1), cs1_n_o is low. After that it stays high, and it is never low together with cs2_n_o.
- R3: cs2_n_o is low from cycle 2 through the last write-enable cycle. It goes high in the same cycle that we_n_o goes high.
- R4: In cycle 3, le_o is 1 with ad_o = 0xFF (low byte of 0xFFFF). In cycle 4, le_o is 0 and ad_o is still 0xFF. Write-enable falls only after le_o has already been low for a cycle.
- R5: addr_hi_o is 0xFF (high byte of 0xFFFF) from cycle 1 through the done cycle.
- R6: we_n_o is low for exactly W = ceil(WE_MIN_NS·CLK_MHZ/1000) cycles, from cycle 5 to cycle 4+W. The switch byte is driven on ad_o for that whole window. At 200 MHz, W = 146, which gives 730 ns, inside 728–736 ns.
- R7: sel_i = 1 writes bank1_i and sel_i = 0 writes bank0_i. Both values are captured at the accepting edge, so later changes to sel_i or to the bank inputs do not alter the byte being written.
- R8: ad_oe_o is 1 exactly in cycles 3 through 4+W, and 0 at all other times.
- R9: done_o is a single-cycle pulse in cycle 5+W. The block is idle again in cycle 6+W.
- R10: A request raised while a cycle is in progress, including during the done cycle, is ignored. The running cycle is unchanged and no second cycle follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Start a bank-switch write (taken only when idle) |
| sel_i | input | 1 | 1 selects the upper-half value, 0 the lower-half value |
| bank0_i | input | 8 | Switch byte for the lower half |
| bank1_i | input | 8 | Switch byte for the upper half |
| addr_hi_o | output | 8 | High address byte |
| ad_o | output | 8 | Multiplexed address/data byte |
| ad_oe_o | output | 1 | Output enable for the AD drivers |
| le_o | output | 1 | Address latch enable, active high |
| we_n_o | output | 1 | Write enable, active low |
| cs1_n_o | output | 1 | First chip-select, active low (pre-pulse) |
| cs2_n_o | output | 1 | Second chip-select, active low |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
All outputs are decoded from registered state, so every result is due a fixed number of rising edges after the accepting edge. The first chip-select pulse is due one edge after acceptance, latch-enable three edges after, and write-enable five edges after. Done is due W+5 edges after acceptance and idle W+6 edges after. The bench counts edges from the accepting edge and compares the full output set at the falling edge of every cycle against the value expected for that cycle number. It also measures the write-enable width independently, and checks that a late change to the inputs or a request during a running cycle leaves every later cycle unchanged.

// File: rtl/bank_wr_seq.sv
module bank_wr_seq #(
  parameter int          CLK_MHZ   = 200,
  parameter int          WE_MIN_NS = 728,
  parameter logic [15:0] REG_ADDR  = 16'hFFFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_i,
  input  logic       sel_i,
  input  logic [7:0] bank0_i,
  input  logic [7:0] bank1_i,
  output logic [7:0] addr_hi_o,
  output logic [7:0] ad_o,
  output logic       ad_oe_o,
  output logic       le_o,
  output logic       we_n_o,
  output logic       cs1_n_o,
  output logic       cs2_n_o,
  output logic       done_o
);

  localparam int WE_RAW = (WE_MIN_NS * CLK_MHZ + 999) / 1000;
  localparam int WE_CYC = (WE_RAW < 1) ? 1 : WE_RAW;
  localparam int CW     = $clog2(WE_CYC + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_PRE, S_SEL, S_LAT, S_HLD, S_WR, S_REL
  } st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [7:0]    dat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
      dat <= 8'h00;
    end else begin
      case (st)
        S_IDLE: if (req_i) begin
          dat <= sel_i ? bank1_i : bank0_i;
          st  <= S_PRE;
        end
        S_PRE: st <= S_SEL;
        S_SEL: st <= S_LAT;
        S_LAT: st <= S_HLD;
        S_HLD: begin
          cnt <= '0;
          st  <= S_WR;
        end
        S_WR: begin
          if (cnt == CW'(WE_CYC - 1)) st <= S_REL;
          else cnt <= cnt + 1'b1;
        end
        S_REL:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  wire addr_ph = (st == S_LAT) || (st == S_HLD);

  assign cs1_n_o   = (st != S_PRE);
  assign cs2_n_o   = !(addr_ph || st == S_SEL || st == S_WR);
  assign le_o      = (st == S_LAT);
  assign we_n_o    = (st != S_WR);
  assign ad_oe_o   = addr_ph || (st == S_WR);
  assign ad_o      = addr_ph ? REG_ADDR[7:0] : ((st == S_WR) ? dat : 8'h00);
  assign addr_hi_o = (st == S_IDLE) ? 8'h00 : REG_ADDR[15:8];
  assign done_o    = (st == S_REL);

endmodule

// File: rtl/bank_wr_seq_chk.sv
module bank_wr_seq_chk #(
  parameter int CLK_MHZ   = 200,
  parameter int WE_MIN_NS = 728
) (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] ad_o,
  input logic       ad_oe_o,
  input logic       le_o,
  input logic       we_n_o,
  input logic       cs1_n_o,
  input logic       cs2_n_o,
  input logic       done_o
);

  localparam int WE_RAW = (WE_MIN_NS * CLK_MHZ + 999) / 1000;
  localparam int WE_CYC = (WE_RAW < 1) ? 1 : WE_RAW;
  localparam int CW     = $clog2(WE_CYC + 2);

  logic [CW-1:0] wl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wl <= '0;
    else if (!we_n_o) wl <= wl + 1'b1;
    else             wl <= '0;
  end

  assert_cs_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs1_n_o || cs2_n_o);

  assert_cs1_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cs1_n_o |=> cs1_n_o && !cs2_n_o);

  assert_latch_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    le_o |-> ad_oe_o && ad_o == 8'hFF && we_n_o && !cs2_n_o);

  assert_we_after_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n_o) |-> $past(!le_o) && !le_o && ad_oe_o);

  assert_we_framed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n_o |-> !cs2_n_o && ad_oe_o && !le_o);

  assert_we_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n_o) |-> wl == CW'(WE_CYC));

  assert_data_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n_o && $past(!we_n_o)) |-> $stable(ad_o));

  assert_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n_o) |-> $rose(cs2_n_o));

  assert_done_after_we_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> we_n_o && cs2_n_o && !ad_oe_o && $past(!we_n_o));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o && cs1_n_o);

endmodule

bind bank_wr_seq bank_wr_seq_chk #(.CLK_MHZ(CLK_MHZ), .WE_MIN_NS(WE_MIN_NS)) chk (
  .clk(clk), .rst_n(rst_n), .ad_o(ad_o), .ad_oe_o(ad_oe_o), .le_o(le_o),
  .we_n_o(we_n_o), .cs1_n_o(cs1_n_o), .cs2_n_o(cs2_n_o), .done_o(done_o)
);

// File: tb/bank_wr_seq_test.sv
`timescale 1ns/1ps
module bank_wr_seq_test;

  localparam int W = 146;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0;
  logic       sel = 1'b0;
  logic [7:0] b0 = 8'h00;
  logic [7:0] b1 = 8'h00;
  logic [7:0] addr_hi, ad;
  logic       oe, le, we_n, cs1_n, cs2_n, done;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  bank_wr_seq uut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .sel_i(sel),
    .bank0_i(b0), .bank1_i(b1), .addr_hi_o(addr_hi), .ad_o(ad),
    .ad_oe_o(oe), .le_o(le), .we_n_o(we_n), .cs1_n_o(cs1_n),
    .cs2_n_o(cs2_n), .done_o(done)
  );

  localparam logic [16:0] VEC [6] = '{
    {1'b0, 8'h28, 8'h2E},
    {1'b1, 8'h28, 8'h2E},
    {1'b0, 8'h20, 8'h31},
    {1'b1, 8'h20, 8'h31},
    {1'b1, 8'h00, 8'hFF},
    {1'b0, 8'hA5, 8'h5A}
  };

  function automatic logic [21:0] snap();
    return {addr_hi, (oe ? ad : 8'h00), oe, le, we_n, cs1_n, cs2_n, done};
  endfunction

  function automatic logic [21:0] expect_at(int n, logic [7:0] d);
    if (n == 1)                return {8'hFF, 8'h00, 6'b0_0_1_0_1_0};
    if (n == 2)                return {8'hFF, 8'h00, 6'b0_0_1_1_0_0};
    if (n == 3)                return {8'hFF, 8'hFF, 6'b1_1_1_1_0_0};
    if (n == 4)                return {8'hFF, 8'hFF, 6'b1_0_1_1_0_0};
    if (n >= 5 && n <= 4 + W)  return {8'hFF, d,     6'b1_0_0_1_0_0};
    if (n == 5 + W)            return {8'hFF, 8'h00, 6'b0_0_1_1_1_1};
    return {8'h00, 8'h00, 6'b0_0_1_1_1_0};
  endfunction

  function automatic string tag_of(int n);
    if (n == 1)     return "R2";
    if (n == 2)     return "R3";
    if (n <= 4)     return "R4";
    if (n <= 4 + W) return "R6";
    if (n == 5 + W) return "R9";
    return "R1";
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // mode 0 plain, 1 change inputs mid-cycle, 2 request while busy
  task automatic run_txn(logic s, logic [7:0] v0, logic [7:0] v1, int mode);
    logic [7:0] d;
    int wl;
    d = s ? v1 : v0;
    wl = 0;
    @(negedge clk);
    sel = s; b0 = v0; b1 = v1; req = 1'b1;
    for (int n = 1; n <= 6 + W; n++) begin
      @(negedge clk);
      if (n == 1 && mode != 2) req = 1'b0;
      if (mode == 1 && n == 2) begin
        sel = ~s; b0 = ~v0; b1 = ~v1;
      end
      if (mode == 2 && n == 3) sel = ~s;
      if (mode == 2 && n == 5 + W) req = 1'b1;
      if (mode == 2 && n == 6 + W) req = 1'b0;
      if (!we_n) wl++;
      check(tag_of(n), 32'(snap()), 32'(expect_at(n, d)), $sformatf("cycle %0d outputs", n));
      if (n == 5)     check("R7", 32'(ad), 32'(d), "switch byte");
      if (n == 3)     check("R5", 32'(addr_hi), 32'hFF, "high address");
      if (n == 4 + W) check("R8", 32'({oe, cs2_n}), 32'b10, "oe/cs2 at last write cycle");
      if (n == 5 + W) check("R8", 32'(oe), 32'd0, "oe at release");
    end
    check("R6", 32'(wl), 32'(W), "write-enable low cycles");
    if (mode == 2) begin
      @(negedge clk);
      check("R10", 32'(snap()), 32'(expect_at(0, d)), "no second cycle");
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 32'(snap()), 32'(expect_at(0, 8'h00)), "reset state");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 32'(snap()), 32'(expect_at(0, 8'h00)), "idle after reset");
    check("R6", 32'(W * 5 >= 728 && W * 5 <= 736), 32'd1, "pulse width in range");

    for (int i = 0; i < 6; i++)
      run_txn(VEC[i][16], VEC[i][15:8], VEC[i][7:0], 0);

    // R7: inputs changed after acceptance
    run_txn(1'b1, 8'h20, 8'h31, 1);
    run_txn(1'b0, 8'h28, 8'h2E, 1);
    // R10: request held through a running cycle and in the done cycle
    run_txn(1'b0, 8'h20, 8'h31, 2);
    run_txn(1'b1, 8'h28, 8'h2E, 2);

    // R1: reset in the middle of the write window
    @(negedge clk);
    sel = 1'b1; b1 = 8'h77; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    repeat (20) @(negedge clk);
    check("R6", 32'(we_n), 32'd0, "write window before reset");
    rst_n = 1'b0;
    #1;
    check("R1", 32'(snap()), 32'(expect_at(0, 8'h00)), "async reset mid-cycle");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", 32'(snap()), 32'(expect_at(0, 8'h00)), "idle after mid-cycle reset");
    run_txn(1'b1, 8'h11, 8'h77, 0);

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule